// File: doc/BRIEF.md
# Packed-Lane Immediate Arithmetic Shifter

This block takes a 32-bit vector shift instruction word together with a wide source vector. It splits the vector into lanes of 8, 16, 32 or 64 bits and shifts every lane right arithmetically by an immediate count. A single 7-bit packed immediate carries both the lane size and the shift count. Each lane's sign bit is copied into the high positions that the shift vacates. Every lane is processed on every instruction. There is no per-lane masking, and the latency is the same whatever the operand data.

The result is registered one cycle after the input strobe. The destination and source register indices and two status flags are registered alongside it. One flag reports a word whose fixed opcode bits do not match. The other reports a reserved lane-size code. In both cases the result register keeps its previous value. The vector width is a parameter and must be a multiple of 128 bits.

Top module: `vshift_imm_top`

## Requirements
- R1: A word matches only when bits 31:24 are 8'h04, bit 21 is 1 and bits 15:10 are 6'b100100. For a non-matching word, `nomatch_flag` is 1, `undef_flag` is 0 and `res_vec` keeps its previous value.
- R2: For a matching word whose 4-bit size code {bits 23:22, bits 20:19} is 4'b0000, `undef_flag` is 1, `nomatch_flag` is 0 and `res_vec` keeps its previous value.
- R3: The lane width comes from the highest set bit of the size code: 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R4: The shift count equals twice the lane width minus the unsigned 7-bit value {size code, bits 18:16}. This count always lies between 1 and the lane width inclusive.
- R5: Each lane of `src_vec` is shifted right on its own, filling with its own sign bit. The result goes into the same lane position of `res_vec`, and every lane is processed.
- R6: A shift equal to the full lane width gives a lane that is all copies of the sign bit: all zeros or all ones.
- R7: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. The latency is one cycle whatever the data, and the outputs hold while `in_valid` is low.
- R8: On every valid word, `dst_idx` takes bits 4:0 and `src_idx` takes bits 9:5, registered with the result.
- R9: A synchronous active-high `rst` clears `out_valid`, both flags, both indices and `res_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand are valid this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | VEC_W | Source vector operand |
| out_valid | output | 1 | Registered outputs updated from the previous cycle's word |
| res_vec | output | VEC_W | Shifted result vector |
| dst_idx | output | 5 | Destination register index |
| src_idx | output | 5 | Source register index |
| undef_flag | output | 1 | Reserved lane-size code in a matching word |
| nomatch_flag | output | 1 | Fixed opcode bits do not match |

## Verification
Two conditions can fall on the same word: the opcode mismatch and the reserved size code. The bench provokes this by sending mismatching words whose size field is 0000. It judges the result by requiring `nomatch_flag` high, `undef_flag` low and the result held. A full-lane-width shift and a sign-bit lane can also coincide in every lane of one word. Directed vectors with alternating negative and positive lanes at the maximum count check that each lane fills with its own sign and never passes through unshifted.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 7;
  localparam int N_SIZES = 4;

  typedef enum logic [1:0] {
    LSEL_8  = 2'd0,
    LSEL_16 = 2'd1,
    LSEL_32 = 2'd2,
    LSEL_64 = 2'd3
  } lane_sel_e;

  typedef struct packed {
    logic             hit;
    logic             rsvd;
    lane_sel_e        sel;
    logic [IMM_W-1:0] amt;
    logic [IDX_W-1:0] zn;
    logic [IDX_W-1:0] zd;
  } dec_t;

  function automatic lane_sel_e top_bit_sel(input logic [3:0] code);
    lane_sel_e s;
    casez (code)
      4'b1???: s = LSEL_64;
      4'b01??: s = LSEL_32;
      4'b001?: s = LSEL_16;
      default: s = LSEL_8;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
  import vshift_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic [3:0]       size_code;
  logic [IMM_W-1:0] imm7;
  logic [7:0]       twice_lw;
  logic [7:0]       diff;
  lane_sel_e        sel;

  always_comb begin
    size_code = {instr[23:22], instr[20:19]};
    imm7      = {size_code, instr[18:16]};
    sel       = top_bit_sel(size_code);
    twice_lw  = 8'd16 << sel;
    diff      = twice_lw - {1'b0, imm7};

    dec.hit  = (instr[31:24] == 8'h04) && instr[21] && (instr[15:10] == 6'b100100);
    dec.rsvd = (size_code == 4'b0000);
    dec.sel  = sel;
    dec.amt  = diff[IMM_W-1:0];
    dec.zn   = instr[9:5];
    dec.zd   = instr[4:0];
  end

endmodule

// File: rtl/vshift_lane.sv
module vshift_lane #(
  parameter int LW = 8,
  parameter int AW = 7
) (
  input  logic [LW-1:0] din,
  input  logic [AW-1:0] amt,
  output logic [LW-1:0] dout
);

  localparam int SW = $clog2(LW);

  logic [SW-1:0] shamt;

  // An arithmetic shift by LW and by LW-1 give the same lane (all sign bits),
  // so the count is clamped to fit a SW-bit shifter.
  always_comb begin
    if (amt >= AW'(LW)) shamt = SW'(LW - 1);
    else                shamt = amt[SW-1:0];
    dout = $signed(din) >>> shamt;
  end

endmodule

// File: rtl/vshift_lane_array.sv
module vshift_lane_array #(
  parameter int VEC_W = 128,
  parameter int LW    = 8,
  parameter int AW    = 7
) (
  input  logic [VEC_W-1:0] src,
  input  logic [AW-1:0]    amt,
  output logic [VEC_W-1:0] res
);

  localparam int NL = VEC_W / LW;

  for (genvar li = 0; li < NL; li++) begin : g_lane
    vshift_lane #(.LW(LW), .AW(AW)) lane_i (
      .din  (src[li*LW +: LW]),
      .amt  (amt),
      .dout (res[li*LW +: LW])
    );
  end

endmodule

// File: rtl/vshift_imm_top.sv
module vshift_imm_top
  import vshift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [VEC_W-1:0]   src_vec,
  output logic               out_valid,
  output logic [VEC_W-1:0]   res_vec,
  output logic [4:0]         dst_idx,
  output logic [4:0]         src_idx,
  output logic               undef_flag,
  output logic               nomatch_flag
);

  localparam int MIN_VEC = 128;

  initial begin
    if (VEC_W % MIN_VEC != 0) $error("VEC_W must be a multiple of 128");
  end

  dec_t             dec;
  logic [VEC_W-1:0] res_by_w [N_SIZES];
  logic [VEC_W-1:0] res_sel;

  vshift_decode dec_i (
    .instr (instr),
    .dec   (dec)
  );

  for (genvar gi = 0; gi < N_SIZES; gi++) begin : g_width
    vshift_lane_array #(.VEC_W(VEC_W), .LW(8 << gi), .AW(IMM_W)) arr_i (
      .src (src_vec),
      .amt (dec.amt),
      .res (res_by_w[gi])
    );
  end

  always_comb begin
    res_sel = res_by_w[dec.sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      res_vec      <= '0;
      dst_idx      <= '0;
      src_idx      <= '0;
      undef_flag   <= 1'b0;
      nomatch_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_idx      <= dec.zd;
        src_idx      <= dec.zn;
        nomatch_flag <= !dec.hit;
        undef_flag   <= dec.hit && dec.rsvd;
        if (dec.hit && !dec.rsvd) res_vec <= res_sel;
      end
    end
  end

endmodule

// File: rtl/vshift_imm_chk.sv
module vshift_imm_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic             out_valid,
  input logic [VEC_W-1:0] res_vec,
  input logic [4:0]       dst_idx,
  input logic [4:0]       src_idx,
  input logic             undef_flag,
  input logic             nomatch_flag
);

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid == ($past(in_valid) && !$past(rst)));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(undef_flag && nomatch_flag));

  assert_hold_on_reject_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && (nomatch_flag || undef_flag) |-> $stable(res_vec));

  assert_dst_index_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> dst_idx == $past(instr[4:0]));

  assert_src_index_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> src_idx == $past(instr[9:5]));

  assert_reserved_size_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && undef_flag |-> $past(instr[23:22]) == 2'b00 && $past(instr[20:19]) == 2'b00);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid && !$past(rst) |-> $stable(res_vec) && $stable(dst_idx));

endmodule

bind vshift_imm_top vshift_imm_chk #(.VEC_W(VEC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .instr        (instr),
  .out_valid    (out_valid),
  .res_vec      (res_vec),
  .dst_idx      (dst_idx),
  .src_idx      (src_idx),
  .undef_flag   (undef_flag),
  .nomatch_flag (nomatch_flag)
);

// File: tb/vshift_imm_tb.sv
`timescale 1ns/1ps
module vshift_imm_top_tb_top;

  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [VW-1:0] src_vec = '0;
  logic          out_valid;
  logic [VW-1:0] res_vec;
  logic [4:0]    dst_idx, src_idx;
  logic          undef_flag, nomatch_flag;

  int n_checks = 0;
  int n_fail   = 0;
  logic [VW-1:0] model_res = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vshift_imm_top #(.VEC_W(VW)) dut_i (
    .clk, .rst, .in_valid, .instr, .src_vec,
    .out_valid, .res_vec, .dst_idx, .src_idx, .undef_flag, .nomatch_flag
  );

  function automatic logic [31:0] mk_word(input logic [3:0] code, input logic [2:0] lo,
                                          input logic [4:0] zn, input logic [4:0] zd);
    return {8'h04, code[3:2], 1'b1, code[1:0], lo, 6'b100100, zn, zd};
  endfunction

  function automatic logic [31:0] mk_shift(input int lw, input int s,
                                           input logic [4:0] zn, input logic [4:0] zd);
    logic [6:0] imm7;
    imm7 = 7'(2 * lw - s);
    return mk_word(imm7[6:3], imm7[2:0], zn, zd);
  endfunction

  function automatic logic [VW-1:0] ref_asr(input logic [VW-1:0] v, input int lw, input int s);
    logic [VW-1:0] r;
    r = '0;
    for (int l = 0; l < VW / lw; l++) begin
      logic [63:0] e, m;
      m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      e = 64'(v >> (l * lw)) & m;
      if (e[lw-1]) e = e | ~m;
      e = $signed(e) >>> s;
      r = r | (VW'(e & m) << (l * lw));
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [VW-1:0] v, input string rtag);
    logic hit, rsvd;
    logic [3:0] code;
    int lw, s;
    code = {w[23:22], w[20:19]};
    hit  = (w[31:24] == 8'h04) && w[21] && (w[15:10] == 6'b100100);
    rsvd = (code == 4'b0000);
    lw = code[3] ? 64 : code[2] ? 32 : code[1] ? 16 : 8;
    s  = 2 * lw - int'({code, w[18:16]});
    if (hit && !rsvd) model_res = ref_asr(v, lw, s);
    @(negedge clk);
    in_valid = 1'b1; instr = w; src_vec = v;
    @(negedge clk);
    in_valid = 1'b0; instr = $urandom; src_vec = rnd_vec();
    chk("R7 out_valid", VW'(out_valid), VW'(1));
    chk("R1 nomatch_flag", VW'(nomatch_flag), VW'(!hit));
    chk("R2 undef_flag", VW'(undef_flag), VW'(hit && rsvd));
    chk("R8 dst_idx", VW'(dst_idx), VW'(w[4:0]));
    chk("R8 src_idx", VW'(src_idx), VW'(w[9:5]));
    chk(rtag, res_vec, model_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] alt, pos;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset out_valid", VW'(out_valid), '0);
    chk("R9 reset res_vec", res_vec, '0);
    chk("R9 reset flags", VW'({undef_flag, nomatch_flag, dst_idx, src_idx}), '0);
    rst = 1'b0;

    // R6: full-width shifts, alternating sign per lane
    for (int g = 0; g < 4; g++) begin
      int lw = 8 << g;
      alt = '0;
      for (int l = 0; l < VW / lw; l++)
        if (l % 2 == 0) alt[l*lw +: 64] = {48'h0, 16'h8000} << (lw - 16);
      if (lw == 8) for (int l = 0; l < VW / 8; l++) alt[l*8 +: 8] = (l % 2 == 0) ? 8'h85 : 8'h7A;
      apply(mk_shift(lw, lw, 5'd3, 5'd17), alt, "R6 full-width shift");
      apply(mk_shift(lw, 1, 5'd9, 5'd1), ~alt, "R4 shift by one");
    end
    pos = {(VW/8){8'h7F}};
    apply(mk_shift(64, 64, 5'd0, 5'd31), pos, "R6 positive full shift gives zero");

    // R7: outputs hold while idle
    @(negedge clk); @(negedge clk);
    chk("R7 idle out_valid low", VW'(out_valid), '0);
    chk("R7 idle result held", res_vec, model_res);

    // R2: reserved size code, result held
    apply(mk_word(4'b0000, 3'd5, 5'd4, 5'd6), rnd_vec(), "R2 reserved size holds result");
    // R1: mismatch with reserved size code also present
    apply({8'h05, 2'b00, 1'b1, 2'b00, 3'd2, 6'b100100, 5'd1, 5'd2}, rnd_vec(), "R1 mismatch holds result");
    apply({8'h04, 2'b01, 1'b0, 2'b10, 3'd2, 6'b100100, 5'd1, 5'd2}, rnd_vec(), "R1 bit21 clear holds result");
    apply({8'h04, 2'b01, 1'b1, 2'b10, 3'd2, 6'b100101, 5'd1, 5'd2}, rnd_vec(), "R1 opcode tail mismatch holds result");

    // R3: size codes with extra low bits set
    apply(mk_word(4'b0011, 3'd7, 5'd2, 5'd3), rnd_vec(), "R3 code 0011 gives 16-bit lanes");
    apply(mk_word(4'b0111, 3'd0, 5'd2, 5'd3), rnd_vec(), "R3 code 0111 gives 32-bit lanes");
    apply(mk_word(4'b1111, 3'd7, 5'd2, 5'd3), rnd_vec(), "R3 code 1111 gives 64-bit lanes");

    // R5: random traffic
    for (int i = 0; i < 400; i++) begin
      int g = $urandom_range(3);
      int lw = 8 << g;
      int s = $urandom_range(lw, 1);
      logic [31:0] w = mk_shift(lw, s, 5'($urandom), 5'($urandom));
      int k = $urandom_range(19);
      if (k == 0) w[31:24] = 8'($urandom);
      else if (k == 1) w = mk_word(4'b0000, 3'($urandom), 5'($urandom), 5'($urandom));
      apply(w, rnd_vec(), "R5 random lane shift");
    end

    // R9: reset mid-stream clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_res = '0;
    chk("R9 reset clears result", res_vec, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule